// File: doc/BRIEF.md
# SPI Mode-3 Sensor Register Port

This block is the serial slave that lets a host processor reach the register file of a sensor hub. The host sends 16-bit frames in SPI mode 3 (clock idles high, the slave samples on the rising edge, most significant bit first). Each frame is either a read request or a write of one byte. A read is answered on the serial output during the frame that follows the request, so the host overlaps the next request with the current answer. A write changes only the one byte it addresses.

The port holds a small set of byte-addressed 16-bit registers. Each register takes two byte addresses, an even and an odd one. There are sample words fed by the sensor datapath, each with a new-data flag that clears on read and an error flag that mirrors a sticky status word. There are also configuration words the host can write, a status word, a command byte that produces a one-clock strobe, and a fixed identification word. SCLK, chip select and MOSI are synchronised into the system clock domain. A frame that does not contain exactly 16 clocks is thrown away and recorded in the status word. The serial output pad is driven only while chip select is low. The pad buffer itself sits outside the block and is steered by an output-enable pin.

Top module: `spi_sensor_port`

## Requirements
- R1: A frame is the set of SCLK rising edges while spi_cs_n is low, MSB first. Frame bit 15 selects write (1) or read (0), bits 14:8 hold a 7-bit byte address, and bits 7:0 hold the write data (ignored for reads).
- R2: A read frame's addressed 16-bit word is shifted out on spi_miso, MSB first, during the next frame. A frame that follows a write frame, a discarded frame or reset shifts out 0x0000.
- R3: spi_miso_oe is 1 exactly while spi_cs_n is low and 0 while it is high.
- R4: Configuration word j sits at byte addresses 0x30+2j (bits 7:0) and 0x31+2j (bits 15:8) and appears on cfg_q[16j+15:16j]. A write changes only the addressed byte. Either byte address reads the whole word. cfg_q changes only on a write frame and resets to 0.
- R5: A write to byte address 0x3E pulses cmd_stb for exactly one clock, with cmd_byte equal to the written data. A write to 0x3F produces no pulse.
- R6: A command byte with bit 4 set clears the status word to 0x0000.
- R7: Sample word i at byte address 0x04+2i reads as {new-data, error, 14-bit sample}. The error bit is 1 whenever the status word is nonzero.
- R8: A smp_vld pulse loads every sample word from smp_data and sets every new-data flag. A read request to a sample word clears its flag when its answer is loaded.
- R9: A read of byte address 0x4A returns 0x3F51.
- R10: A frame with a clock count other than 16 is discarded: it writes nothing, it cancels any pending read, and it sets status bit 3.
- R11: The status word at 0x3C is read-only. Its bits are sticky and are set from stat_set. Reads of any unmapped address, including the command address, return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad buffer |
| smp_vld | input | 1 | One-clock strobe: new samples present |
| smp_data | input | NUM_CH*14 | Packed 14-bit samples, channel 0 in the low bits |
| stat_set | input | 16 | Status bits to set this clock |
| cfg_q | output | NUM_CFG*16 | Packed configuration words |
| cmd_stb | output | 1 | One-clock command strobe |
| cmd_byte | output | 8 | Last command byte written |

## Verification
Every input crosses two synchroniser flops and one edge detector. A chip-select fall therefore loads the answer word on the third clock edge. An SCLK rise shifts on the third edge. A chip-select rise commits writes, status updates and the command strobe on the third edge. The bench waits four clocks after a chip-select fall before the first SCLK fall, keeps each SCLK half-period at four clocks, and samples MISO at the rising SCLK moment, before the shift it causes. After chip select rises it waits six clocks before comparing the configuration outputs and the strobe record with its model. The output-enable pin is combinational from chip select, so it is compared on every clock.

// File: rtl/snsp_pkg.sv
package snsp_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned DATA_W     = WORD_W - 2;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned FRAME_BITS = 1 + ADDR_W + 8;

  localparam logic [ADDR_W-1:0] SMP_BASE  = 7'h04;
  localparam logic [ADDR_W-1:0] CFG_BASE  = 7'h30;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h3C;
  localparam logic [ADDR_W-1:0] CMD_ADDR  = 7'h3E;
  localparam logic [ADDR_W-1:0] ID_ADDR   = 7'h4A;
  localparam logic [WORD_W-1:0] ID_VALUE  = 16'h3F51;

  localparam int unsigned STAT_LINK_BIT = 3;
  localparam int unsigned CMD_CLR_BIT   = 4;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        dat;
  } frame_t;

  // word slot k of a window starting at base: compare word addresses
  function automatic logic slot_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base,
                                    input int unsigned k);
    logic [ADDR_W-1:0] want;
    want = base + ADDR_W'(2 * k);
    return a[ADDR_W-1:1] == want[ADDR_W-1:1];
  endfunction

  function automatic logic [WORD_W-1:0] smp_word(input logic nd,
                                                 input logic [WORD_W-1:0] stat,
                                                 input logic [DATA_W-1:0] d);
    return {nd, |stat, d};
  endfunction
endpackage

// File: rtl/snsp_sync.sv
module snsp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/snsp_link.sv
module snsp_link
  import snsp_pkg::*;
#(
  parameter int unsigned FB        = FRAME_BITS,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [FB-1:0] tx_word,
  output logic          frame_start,
  output logic          fr_good,
  output logic          fr_bad,
  output logic [FB-1:0] fr_word,
  output logic          miso,
  output logic          miso_oe
);
  localparam int unsigned CNT_W = $clog2(FB) + 1;

  logic sclk_s, cs_s, mosi_s;
  logic sclk_q, cs_q;
  logic sclk_rise, frame_end;
  logic [CNT_W-1:0] cnt;
  logic [FB-1:0] rx_sr, tx_sr;

  snsp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  snsp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  snsp_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

  assign frame_start = cs_q & ~cs_s;
  assign frame_end   = ~cs_q & cs_s;
  assign sclk_rise   = ~sclk_q & sclk_s & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      cnt    <= '0;
      rx_sr  <= '0;
      tx_sr  <= '0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      if (frame_start) begin
        cnt   <= '0;
        tx_sr <= tx_word;
      end else if (sclk_rise) begin
        rx_sr <= {rx_sr[FB-2:0], mosi_s};
        tx_sr <= {tx_sr[FB-2:0], 1'b0};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end

  assign fr_good = frame_end && (cnt == CNT_W'(FB));
  assign fr_bad  = frame_end && (cnt != CNT_W'(FB));
  assign fr_word = rx_sr;
  assign miso    = tx_sr[FB-1];
  assign miso_oe = ~cs_n;
endmodule

// File: rtl/snsp_regs.sv
module snsp_regs
  import snsp_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_CFG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_req,
  input  logic                      fr_bad,
  input  logic [ADDR_W-1:0]         fr_addr,
  input  logic [7:0]                fr_dat,
  input  logic                      frame_start,
  input  logic                      smp_vld,
  input  logic [NUM_CH*DATA_W-1:0]  smp_data,
  input  logic [WORD_W-1:0]         stat_set,
  output logic [WORD_W-1:0]         tx_word,
  output logic [NUM_CFG*WORD_W-1:0] cfg_q,
  output logic [WORD_W-1:0]         status,
  output logic [NUM_CH-1:0]         nd,
  output logic                      cmd_stb,
  output logic [7:0]                cmd_byte
);
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] rd_val;
  logic [DATA_W-1:0] smp_q [NUM_CH];
  logic              cmd_hit, clr_hit;

  // pending read: set by a good read frame, dropped by any other frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
    end else if (wr_en || rd_req) begin
      pend_vld  <= rd_req;
      pend_addr <= fr_addr;
    end else if (fr_bad) begin
      pend_vld  <= 1'b0;
    end
  end

  // sample words with new-data flags
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic rd_hit;
      assign rd_hit = frame_start && pend_vld && slot_hit(pend_addr, SMP_BASE, i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          smp_q[i] <= '0;
          nd[i]    <= 1'b0;
        end else if (smp_vld) begin
          smp_q[i] <= smp_data[i*DATA_W +: DATA_W];
          nd[i]    <= 1'b1;
        end else if (rd_hit) begin
          nd[i]    <= 1'b0;
        end
      end
    end
  endgenerate

  // configuration words, byte writable
  generate
    for (genvar j = 0; j < NUM_CFG; j++) begin : g_cfg
      logic hit;
      assign hit = wr_en && slot_hit(fr_addr, CFG_BASE, j);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[j*WORD_W +: WORD_W] <= '0;
        end else if (hit) begin
          if (fr_addr[0]) cfg_q[j*WORD_W + 8 +: 8] <= fr_dat;
          else            cfg_q[j*WORD_W     +: 8] <= fr_dat;
        end
      end
    end
  endgenerate

  // command byte and sticky status
  assign cmd_hit = wr_en && (fr_addr == CMD_ADDR);
  assign clr_hit = cmd_hit && fr_dat[CMD_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb  <= 1'b0;
      cmd_byte <= '0;
      status   <= '0;
    end else begin
      cmd_stb <= cmd_hit;
      if (cmd_hit) cmd_byte <= fr_dat;
      status <= (clr_hit ? '0 : status) | stat_set
                | (fr_bad ? WORD_W'(1) << STAT_LINK_BIT : '0);
    end
  end

  // read multiplexer on the pending address
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (slot_hit(pend_addr, SMP_BASE, i)) rd_val = smp_word(nd[i], status, smp_q[i]);
    for (int j = 0; j < NUM_CFG; j++)
      if (slot_hit(pend_addr, CFG_BASE, j)) rd_val = cfg_q[j*WORD_W +: WORD_W];
    if (slot_hit(pend_addr, STAT_ADDR, 0)) rd_val = status;
    if (slot_hit(pend_addr, ID_ADDR, 0))   rd_val = ID_VALUE;
  end

  assign tx_word = pend_vld ? rd_val : '0;
endmodule

// File: rtl/spi_sensor_port.sv
module spi_sensor_port
  import snsp_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_CFG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  output logic                      spi_miso_oe,
  input  logic                      smp_vld,
  input  logic [NUM_CH*DATA_W-1:0]  smp_data,
  input  logic [WORD_W-1:0]         stat_set,
  output logic [NUM_CFG*WORD_W-1:0] cfg_q,
  output logic                      cmd_stb,
  output logic [7:0]                cmd_byte
);
  logic                    frame_start, fr_good, fr_bad;
  logic [FRAME_BITS-1:0]   fr_raw;
  frame_t                  fr;
  logic                    wr_en, rd_req;
  logic [WORD_W-1:0]       tx_word, status_w;
  logic [NUM_CH-1:0]       nd_w;

  snsp_link #(.FB(FRAME_BITS)) u_link (
    .clk(clk), .rst_n(rst_n),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(tx_word),
    .frame_start(frame_start), .fr_good(fr_good), .fr_bad(fr_bad),
    .fr_word(fr_raw),
    .miso(spi_miso), .miso_oe(spi_miso_oe));

  assign fr     = frame_t'(fr_raw);
  assign wr_en  = fr_good &&  fr.wr;
  assign rd_req = fr_good && !fr.wr;

  snsp_regs #(.NUM_CH(NUM_CH), .NUM_CFG(NUM_CFG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .rd_req(rd_req), .fr_bad(fr_bad),
    .fr_addr(fr.addr), .fr_dat(fr.dat),
    .frame_start(frame_start),
    .smp_vld(smp_vld), .smp_data(smp_data), .stat_set(stat_set),
    .tx_word(tx_word), .cfg_q(cfg_q), .status(status_w), .nd(nd_w),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte));
endmodule

// File: rtl/spi_sensor_port_chk.sv
module spi_sensor_port_chk
  import snsp_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned NUM_CFG = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      fr_bad,
  input logic                      smp_vld,
  input logic [NUM_CH-1:0]         nd,
  input logic [WORD_W-1:0]         status,
  input logic [WORD_W-1:0]         stat_set,
  input logic                      cmd_stb,
  input logic [7:0]                cmd_byte,
  input logic [NUM_CFG*WORD_W-1:0] cfg_q
);
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

  // R5
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_stb) && cmd_byte[CMD_CLR_BIT] && ($past(stat_set) == '0) |-> status == '0);

  // R8
  nd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> (&nd));

  // R10
  link_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_bad |=> status[STAT_LINK_BIT]);
endmodule

bind spi_sensor_port spi_sensor_port_chk #(.NUM_CH(NUM_CH), .NUM_CFG(NUM_CFG)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fr_bad(fr_bad),
  .smp_vld(smp_vld), .nd(nd_w), .status(status_w), .stat_set(stat_set),
  .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .cfg_q(cfg_q));

// File: tb/spi_sensor_port_bench.sv
module spi_sensor_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NCFG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic smp_vld = 1'b0;
  logic [NCH*14-1:0] smp_data = '0;
  logic [15:0] stat_set = '0;
  logic [NCFG*16-1:0] cfg_q;
  logic cmd_stb;
  logic [7:0] cmd_byte;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // behavioural model state
  logic [15:0] m_cfg [NCFG];
  logic [13:0] m_dat [NCH];
  bit          m_nd  [NCH];
  logic [15:0] m_stat;
  bit          m_pend;
  logic [6:0]  m_paddr;
  int          exp_cmds;
  logic [7:0]  exp_cmd_byte;
  int          seen_cmds = 0;
  logic [7:0]  seen_cmd_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sensor_port #(.NUM_CH(NCH), .NUM_CFG(NCFG)) u_spi_sensor_port (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .smp_vld(smp_vld), .smp_data(smp_data), .stat_set(stat_set),
    .cfg_q(cfg_q), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte));

  always @(posedge clk) if (rst_n && cmd_stb) begin
    seen_cmds <= seen_cmds + 1;
    seen_cmd_byte <= cmd_byte;
  end

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R3: output enable compared on every clock
  always @(negedge clk) if (!done) check16("R3", {15'd0, spi_miso_oe}, {15'd0, !spi_cs_n});

  function automatic logic [15:0] mread(input logic [6:0] a);
    int w = int'(a) / 2;
    for (int i = 0; i < NCH; i++) if (w == 2 + i) return {m_nd[i], m_stat != 0, m_dat[i]};
    for (int j = 0; j < NCFG; j++) if (w == 24 + j) return m_cfg[j];
    if (w == 30) return m_stat;
    if (w == 37) return 16'h3F51;
    return 16'h0000;
  endfunction

  task automatic check_cfg(input string tag);
    for (int j = 0; j < NCFG; j++) check16(tag, cfg_q[j*16 +: 16], m_cfg[j]);
  endtask

  task automatic check_cmd(input string tag);
    check16(tag, 16'(seen_cmds), 16'(exp_cmds));
    check16(tag, {8'd0, seen_cmd_byte}, {8'd0, exp_cmd_byte});
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input string tag);
    logic [15:0] rxw = '0;
    logic [15:0] expw;
    @(negedge clk);
    spi_cs_n = 1'b0;
    expw = m_pend ? mread(m_paddr) : 16'h0000;
    if (m_pend) for (int i = 0; i < NCH; i++) if (int'(m_paddr) / 2 == 2 + i) m_nd[i] = 0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      spi_sclk = 1'b0;
      spi_mosi = w[15-b];
      repeat (4) @(negedge clk);
      spi_sclk = 1'b1;
      rxw[15-b] = spi_miso;
      repeat (4) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    if (nbits == 16) begin
      check16(tag, rxw, expw);
      if (w[15]) begin
        for (int j = 0; j < NCFG; j++)
          if (int'(w[14:8]) / 2 == 24 + j) begin
            if (w[8]) m_cfg[j][15:8] = w[7:0];
            else      m_cfg[j][7:0]  = w[7:0];
          end
        if (w[14:8] == 7'h3E) begin
          exp_cmds++;
          exp_cmd_byte = w[7:0];
          if (w[4]) m_stat = 16'h0000;
        end
        m_pend = 0;
      end else begin
        m_pend = 1;
        m_paddr = w[14:8];
      end
    end else begin
      m_stat[3] = 1'b1;
      m_pend = 0;
    end
  endtask

  task automatic load_samples(input logic [13:0] s0, s1, s2, s3);
    @(negedge clk);
    smp_data = {s3, s2, s1, s0};
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    m_dat[0] = s0; m_dat[1] = s1; m_dat[2] = s2; m_dat[3] = s3;
    for (int i = 0; i < NCH; i++) m_nd[i] = 1;
  endtask

  task automatic raise_status(input logic [15:0] v);
    @(negedge clk);
    stat_set = v;
    @(negedge clk);
    stat_set = '0;
    m_stat = m_stat | v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int j = 0; j < NCFG; j++) m_cfg[j] = '0;
    for (int i = 0; i < NCH; i++) begin m_dat[i] = '0; m_nd[i] = 0; end
    m_stat = '0; m_pend = 0; m_paddr = '0; exp_cmds = 0; exp_cmd_byte = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_cfg("R4 reset");
    check_cmd("R5 reset");

    // R1 R2 R9: first answer after reset is empty, then the identity word
    frame(16'h4A00, 16, "R2 after reset");
    frame(16'h0000, 16, "R9 identity");
    // R11 unmapped address 0x00 answers zero during this write frame
    frame(16'hB0A5, 16, "R11 unmapped");
    frame(16'hB15A, 16, "R2 after write");
    check_cfg("R4 both bytes");
    frame(16'h3100, 16, "R2 after write");
    frame(16'hB3C3, 16, "R4 odd address read");
    check_cfg("R4 high byte only");
    frame(16'h3200, 16, "R2 after write");
    frame(16'h0000, 16, "R4 low byte kept");

    // R7 R8 samples and new-data flags
    load_samples(14'h1234, 14'h3FFF, 14'h0001, 14'h2000);
    frame(16'h0400, 16, "R11 unmapped");
    frame(16'h0600, 16, "R7 sample 0 flagged");
    frame(16'h0600, 16, "R8 sample 1 flagged");
    frame(16'h0A00, 16, "R8 flag cleared");
    frame(16'h0000, 16, "R7 sample 3");

    // R11 sticky status, read only; R7 error bit
    raise_status(16'h0001);
    frame(16'h0800, 16, "R11 unmapped");
    frame(16'hBCFF, 16, "R7 error bit");
    frame(16'h3C00, 16, "R2 after write");
    frame(16'h0000, 16, "R11 status write ignored");

    // R5 R6 command
    frame(16'hBE10, 16, "R11 unmapped");
    check_cmd("R5 strobe");
    frame(16'hBF22, 16, "R2 after write");
    check_cmd("R5 high byte no strobe");
    frame(16'h3C00, 16, "R2 after write");
    frame(16'h3E00, 16, "R6 status cleared");
    frame(16'h0000, 16, "R11 command reads zero");

    // R10 short frame
    frame(16'h3000, 16, "R11 unmapped");
    frame(16'hB0FF, 8, "R10 short");
    check_cfg("R10 no write");
    frame(16'h3C00, 16, "R10 pending dropped");
    frame(16'h0000, 16, "R10 status bit 3");
    frame(16'h7F00, 16, "R11 unmapped");
    frame(16'h0000, 16, "R11 top address");
    check_cmd("R5 final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule